// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Transceiver

This block moves one byte at a time over a three-wire clocked serial link: a serial clock, a data-out line and a data-in line. It shifts out a parallel transmit byte and, at the same time, assembles the byte arriving on the data-in line. The received byte is presented in parallel when the transfer ends. The same block can be the clock master or a slave. As master it derives the serial clock from the system clock through one of seven power-of-two divisors, and the clock moves only while a transfer is running. As slave it leaves the clock pin undriven and follows an external clock, which it brings into the system clock domain through a two-flop synchroniser.

Each transfer is configured by five controls: master/slave mode, a 3-bit rate code, clock polarity, clock phase and bit order. These are read when a transfer is accepted and held until it ends. The transmit side behaves as a valid/ready pair. `start_i` is the valid, and `busy_o` low is the ready. A start that arrives while `busy_o` is high is dropped rather than queued, so the source must hold it or raise it again once the block is idle. The receive side has no back-pressure. `done_o` is a one-cycle valid, and `rx_byte_o` holds its value until the next transfer starts to shift.

Top module: `sync_serial_xcvr`

## Requirements
- R1: The rate code selects the master clock divisor. Codes 0,1,2,3,4,5,6 give 256,128,64,32,16,8,4, and code 7 behaves as 4. Each serial clock half period lasts divisor/2 system cycles. The first clock edge comes divisor/2 cycles after the cycle in which the start is accepted.
- R2: In master mode, `sclk_oe_o` is 1. Every transfer produces exactly 16 serial clock edges, and no edge occurs while the block is idle.
- R3: While idle, `sclk_o` equals `cpol_i` from the previous cycle. A transfer therefore begins and ends at the polarity level.
- R4: The edges of a transfer are numbered 0 to 15, and even-numbered edges are leading edges. With `cpha_i`=0, data is sampled on leading edges and changed on trailing edges, and the first bit is on `sdo_o` before edge 0. With `cpha_i`=1, data changes on leading edges from edge 2 onwards and is sampled on trailing edges.
- R5: With `lsb_first_i`=1, bit 0 of the byte is sent and received first, and bit 7 last.
- R6: With `lsb_first_i`=0, bit 7 is sent and received first, and bit 0 last.
- R7: `busy_o` is high from the cycle after the start is accepted through the cycle of the 16th edge. For exactly one cycle after the 16th edge, `done_o` is high and `busy_o` is low, and the received byte is valid on `rx_byte_o` at that point.
- R8: In slave mode, `sclk_oe_o` is 0. Edges on `sclk_i` are detected after a two-flop synchroniser, and the data-in line is delayed by the same amount. With an external clock no faster than a quarter of the system clock, the slave receives the byte the master sends.
- R9: A start request made while `busy_o` is high is ignored. A start made while `busy_o` is low is accepted, including the cycle in which `done_o` is high.
- R10: Mode, rate code, phase, bit order and transmit byte are captured when the start is accepted. Changing them during a transfer has no effect on that transfer.
- R11: After reset, `busy_o`=0, `done_o`=0 and `rx_byte_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master (drives the clock), 0 = slave |
| rate_sel_i | input | 3 | Master clock divisor code |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Clock phase |
| lsb_first_i | input | 1 | Bit order: 1 = LSB first |
| start_i | input | 1 | Transfer request (valid) |
| tx_byte_i | input | 8 | Byte to transmit |
| busy_o | output | 1 | Transfer in progress (not ready) |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_byte_o | output | 8 | Received byte |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe_o | output | 1 | Output enable for the serial clock pin |
| sclk_i | input | 1 | Serial clock from the pin in slave mode |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
Two events can fall in the same cycle: the end of one transfer, marked by the `done_o` pulse, and the acceptance of the next start. The bench holds `start_i` high throughout a master transfer. While that transfer runs, it also swaps the transmit byte and flips the bit order. It then checks three things. The running transfer still delivers the original byte in the original order to a paired slave. Busy is low in the done cycle and high again in the cycle after it. The follow-on transfer carries the new byte in the new order. Beyond that case, the bench sweeps every rate code against all four polarity/phase combinations and both bit orders. For each configuration it computes the edge timing and serial bit order arithmetically.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  typedef struct packed {
    logic       master;
    logic [2:0] rate;
    logic       cpha;
    logic       lsb_first;
  } ssx_cfg_t;

  // half period in system cycles: code 0 -> 128 ... code 6 -> 2, code 7 -> 2
  function automatic logic [7:0] ssx_half(input logic [2:0] sel);
    if (sel == 3'd7) return 8'd2;
    return 8'(128 >> sel);
  endfunction

endpackage

// File: rtl/ssx_master_clk.sv
module ssx_master_clk
  import ssx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] rate,
  input  logic       cpol_idle,
  output logic       tick,
  output logic       sclk
);
  logic [7:0] cnt_q;
  logic [7:0] half;

  assign half = ssx_half(rate);
  assign tick = run && (cnt_q == half - 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sclk  <= cpol_idle;
    end else if (tick) begin
      cnt_q <= '0;
      sclk  <= ~sclk;
    end else begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk == $past(cpol_idle)); // R3
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

endmodule

// File: rtl/ssx_slave_sync.sv
module ssx_slave_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic edge_o,
  output logic data_o
);
  logic [STAGES:0]   clk_sr;
  logic [STAGES-1:0] dat_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sr <= '0;
      dat_sr <= '0;
    end else begin
      clk_sr <= {clk_sr[STAGES-1:0], sclk_i};
      dat_sr <= {dat_sr[STAGES-2:0], sdi_i};
    end
  end

  assign edge_o = clk_sr[STAGES] ^ clk_sr[STAGES-1];
  assign data_o = dat_sr[STAGES-1];

  AST_SLV_EDGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R8

endmodule

// File: rtl/ssx_shift_core.sv
module ssx_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              edge_ev,
  input  logic              sdi,
  input  logic              cpha,
  input  logic              lsb_first,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sdo
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam int IW    = $clog2(DATA_W);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);
  localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

  logic [EW-1:0]     edge_idx;
  logic [IW-1:0]     tx_idx;
  logic [DATA_W-1:0] tx_hold;
  logic [DATA_W-1:0] rx_sr;
  logic              samp, adv, last;
  logic [DATA_W-1:0] rx_next;
  logic [IW-1:0]     sel;

  assign samp    = (~edge_idx[0]) ^ cpha;
  assign last    = (edge_idx == LAST);
  assign adv     = !samp && (cpha ? (edge_idx != '0) : !last);
  assign rx_next = lsb_first ? {sdi, rx_sr[DATA_W-1:1]} : {rx_sr[DATA_W-2:0], sdi};
  assign sel     = lsb_first ? tx_idx : (TOP - tx_idx);
  assign sdo     = tx_hold[sel];
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      edge_idx <= '0;
      tx_idx   <= '0;
      tx_hold  <= '0;
      rx_sr    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        tx_hold  <= tx_byte;
        tx_idx   <= '0;
        edge_idx <= '0;
      end else if (busy && edge_ev) begin
        edge_idx <= edge_idx + 1'b1;
        if (samp)     rx_sr  <= rx_next;
        else if (adv) tx_idx <= tx_idx + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(tx_hold)); // R10

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_i,
  input  logic [2:0]        rate_sel_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sclk_i,
  output logic              sdo_o,
  input  logic              sdi_i
);
  ssx_cfg_t cfg_q;
  logic     accept;
  logic     m_tick, s_edge, s_data;
  logic     edge_ev, sdi_sel;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= '{master: master_i, rate: rate_sel_i, cpha: cpha_i, lsb_first: lsb_first_i};
    end
  end

  ssx_master_clk u_mclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_o && cfg_q.master),
    .rate      (cfg_q.rate),
    .cpol_idle (cpol_i),
    .tick      (m_tick),
    .sclk      (sclk_o)
  );

  ssx_slave_sync #(.STAGES(SYNC_STAGES)) u_ssync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .edge_o (s_edge),
    .data_o (s_data)
  );

  assign edge_ev = cfg_q.master ? m_tick : s_edge;
  assign sdi_sel = cfg_q.master ? sdi_i  : s_data;

  ssx_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .tx_byte   (tx_byte_i),
    .edge_ev   (edge_ev),
    .sdi       (sdi_sel),
    .cpha      (cfg_q.cpha),
    .lsb_first (cfg_q.lsb_first),
    .busy      (busy_o),
    .done      (done_o),
    .rx_byte   (rx_byte_o),
    .sdo       (sdo_o)
  );

  assign sclk_oe_o = busy_o ? cfg_q.master : master_i;

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R9
  AST_SLAVE_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cfg_q.master) |=> $stable(sclk_o) || !busy_o); // R8

endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] rate = '0;
  logic cpol = 1'b0, cpha = 1'b0;
  logic m_lsb = 1'b0, s_lsb = 1'b0;
  logic m_start = 1'b0, s_start = 1'b0;
  logic [7:0] m_tx = '0, s_tx = '0;
  logic m_busy, m_done, m_sclk, m_oe, m_sdo;
  logic s_busy, s_done, s_sclk, s_oe, s_sdo;
  logic [7:0] m_rx, s_rx;

  sync_serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .master_i(1'b1), .rate_sel_i(rate), .cpol_i(cpol),
    .cpha_i(cpha), .lsb_first_i(m_lsb), .start_i(m_start), .tx_byte_i(m_tx),
    .busy_o(m_busy), .done_o(m_done), .rx_byte_o(m_rx), .sclk_o(m_sclk),
    .sclk_oe_o(m_oe), .sclk_i(1'b0), .sdo_o(m_sdo), .sdi_i(s_sdo));

  sync_serial_xcvr slave_i (
    .clk(clk), .rst_n(rst_n), .master_i(1'b0), .rate_sel_i(rate), .cpol_i(cpol),
    .cpha_i(cpha), .lsb_first_i(s_lsb), .start_i(s_start), .tx_byte_i(s_tx),
    .busy_o(s_busy), .done_o(s_done), .rx_byte_o(s_rx), .sclk_o(s_sclk),
    .sclk_oe_o(s_oe), .sclk_i(m_sclk), .sdo_o(s_sdo), .sdi_i(m_sdo));

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // serial-line monitor on the master side
  logic prev_sclk = 1'b0, prev_busy = 1'b0;
  int busycnt = 0, edges = 0, first_at = 0, capidx = 0;
  logic [7:0] cap = '0;
  bit s_seen = 0, m_seen = 0;

  always @(negedge clk) begin
    if (m_busy && !prev_busy) begin
      busycnt = 0; edges = 0; capidx = 0; first_at = 0;
    end
    if (m_busy) busycnt++;
    if ((m_sclk != prev_sclk) && (m_busy || m_done)) begin
      if (edges == 0) first_at = busycnt;
      if ((((edges % 2) == 0) ? 1'b1 : 1'b0) ^ cpha) begin
        if (capidx < 8) cap[capidx] = m_sdo;
        capidx++;
      end
      edges++;
    end
    if (s_done) s_seen = 1;
    if (m_done) m_seen = 1;
    prev_sclk = m_sclk;
    prev_busy = m_busy;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  function automatic logic [7:0] order(input logic [7:0] b, input logic lsb);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = lsb ? b[j] : b[7-j];
    return r;
  endfunction

  task automatic run_xfer(input int code, input logic pol, input logic ph,
                          input logic lsb, input logic [7:0] mt, input logic [7:0] st);
    int half;
    half = ((code == 7) ? 4 : (256 >> code)) / 2;
    rate = 3'(code); cpol = pol; cpha = ph; m_lsb = lsb; s_lsb = lsb;
    repeat (6) tick();
    s_seen = 0; m_seen = 0;
    m_tx = mt; s_tx = st; m_start = 1'b1; s_start = 1'b1;
    tick();
    m_start = 1'b0; s_start = 1'b0;
    while (!m_seen) tick();
    repeat (8) tick();
    check(first_at == half + 1, "R1 first edge", first_at, half + 1);
    check(busycnt == 16 * half, "R7 busy length", busycnt, 16 * half);
    check(edges == 16, "R2 edge count", edges, 16);
    check(m_oe == 1'b1, "R2 master oe", m_oe, 1);
    check(m_sclk == pol, "R3 idle level", m_sclk, pol);
    if (lsb) check(cap == order(mt, 1'b1), "R5 serial order", cap, order(mt, 1'b1));
    else     check(cap == order(mt, 1'b0), "R6 serial order", cap, order(mt, 1'b0));
    check(s_seen && s_rx == mt, "R8 slave receive", s_rx, mt);
    check(s_oe == 1'b0, "R8 slave oe", s_oe, 0);
    if (code <= 4) check(m_rx == st, "R4 master receive", m_rx, st);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check(m_busy == 1'b0, "R11 busy", m_busy, 0);
    check(m_done == 1'b0, "R11 done", m_done, 0);
    check(m_rx == 8'h00, "R11 rx", m_rx, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    for (int code = 0; code < 8; code++)
      for (int md = 0; md < 4; md++)
        for (int lb = 0; lb < 2; lb++) begin
          logic [7:0] mt, st;
          mt = 8'((8'hA5 ^ (code * 37 + md * 11 + lb * 90)) & 8'hFF);
          st = 8'((~mt) ^ 8'(code * 5 + md));
          run_xfer(code, md[1], md[0], lb[0], mt, st);
        end

    // start held through a transfer, settings changed mid-transfer
    rate = 3'd4; cpol = 1'b0; cpha = 1'b0; m_lsb = 1'b0; s_lsb = 1'b0;
    repeat (6) tick();
    s_seen = 0;
    m_tx = 8'h3C; s_tx = 8'h00; m_start = 1'b1; s_start = 1'b1;
    tick();
    s_start = 1'b0; m_tx = 8'hD2; m_lsb = 1'b1;
    while (!m_done) tick();
    check(m_busy == 1'b0, "R7 busy low with done", m_busy, 0);
    tick();
    check(m_done == 1'b0, "R7 done one cycle", m_done, 0);
    check(m_busy == 1'b1, "R9 start accepted in done cycle", m_busy, 1);
    m_start = 1'b0;
    while (!m_done) tick();
    repeat (8) tick();
    check(s_seen && s_rx == 8'h3C, "R10 first transfer kept byte and order", s_rx, 8'h3C);
    check(cap == order(8'hD2, 1'b1), "R9 follow-on transfer", cap, order(8'hD2, 1'b1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule